// File: doc/BRIEF.md
# Multi-Sector Erase Selection Window

This block gathers the sectors that a multi-sector erase will operate on. The command decoder in a flash interface pulses an add strobe with a 17-bit byte address each time it sees a complete sector-erase command. The block maps that address onto one of seven unequal sectors and sets the matching bit of a selection mask. It then holds an acceptance window open, and every further accepted command extends that window. When a full window passes with no new command, the block closes the selection, raises an erase-start pulse and holds the mask steady for the erase engine.

While the window is open, a suspend request leaves the selection alone. Any other command, which the decoder reports on the abort strobe, throws the selection away and returns the block to idle. After erasure has begun, the block ignores further additions and aborts. The mask is released only when the erase engine reports that it has finished. The window length is a parameter counted in clock cycles. Its default is the cycle count that makes 50 µs at the configured clock rate.

Top module: `sect_erase_window`

## Requirements
- R1: After reset the mask is all zero, and window-active, window-expired and erase-start are all low. Whenever the block is neither collecting nor erasing, the mask reads zero.
- R2: Mask bit i stands for sector i. The sectors map as follows: 0 = 0x00000–0x07FFF, 1 = 0x08000–0x0FFFF, 2 = 0x10000–0x17FFF, 3 = 0x18000–0x1BFFF, 4 = 0x1C000–0x1CFFF, 5 = 0x1D000–0x1DFFF, 6 = 0x1E000–0x1FFFF.
- R3: An add strobe sampled while idle sets window-active and the sector's mask bit in the next cycle.
- R4: While the window is open, each add ORs its sector into the mask. Adds may come in any order, and adding a sector that is already selected leaves the mask unchanged.
- R5: Every accepted add restarts the window. Window-active stays high for exactly WIN_CYCLES cycles after the last accepted add.
- R6: When the window expires, erase-start is high for exactly one cycle. In that same cycle window-expired rises and window-active falls.
- R7: An abort while the window is open clears the mask and returns the block to idle with no erase-start. An abort while idle has no effect.
- R8: A suspend strobe while the window is open changes neither the mask nor the expiry time.
- R9: While erasing, add strobes and aborts are ignored. The mask stays stable and window-expired stays high.
- R10: An erase-done strobe while erasing clears the mask and window-expired in the next cycle. Outside erasing, erase-done has no effect.
- R11: When abort and add arrive in the same cycle during the window, the abort wins and the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| add_vld | input | 1 | A sector-erase command completed |
| add_addr | input | 17 | Byte address carried by that command |
| abort | input | 1 | Any other command arrived |
| suspend | input | 1 | Erase-suspend command arrived |
| erase_done | input | 1 | Erase engine finished |
| sector_mask | output | 7 | Selected sectors, bit i = sector i |
| win_active | output | 1 | Acceptance window open |
| win_expired | output | 1 | Window closed, erase in progress |
| erase_start | output | 1 | One-cycle pulse when erasure begins |

## Verification
The hardest case to reach is an expiry that comes exactly WIN_CYCLES cycles after the last add. That add has to follow earlier adds spaced just inside the window, with a suspend strobe dropped in the middle. The bench shortens the window to twelve cycles. It adds sectors at gaps of WIN_CYCLES-1 cycles, so each add lands right before the window would have closed, and it places a suspend between them. It then counts cycles from the final add to the erase-start pulse. A behavioural model tracks the age of the last add on every cycle, so any off-by-one in restart or expiry shows up as a mismatch.

// File: rtl/sew_pkg.sv
package sew_pkg;
    localparam int N_SECT  = 7;
    localparam int ADDR_W  = 17;
    localparam int BLK_LSB = 12;
    localparam int BLK_W   = ADDR_W - BLK_LSB;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_ERASE   = 2'd2
    } sew_state_t;

    typedef struct packed {
        sew_state_t        st;
        logic [N_SECT-1:0] mask;
        logic              start;
    } sew_regs_t;

    // First 4 KB block of each sector (top-boot arrangement)
    function automatic int sect_first_blk(input int idx);
        case (idx)
            0:       return 0;
            1:       return 8;
            2:       return 16;
            3:       return 24;
            4:       return 28;
            5:       return 29;
            default: return 30;
        endcase
    endfunction

    // Size of each sector in 4 KB blocks
    function automatic int sect_num_blk(input int idx);
        case (idx)
            0, 1, 2: return 8;
            3:       return 4;
            4, 5:    return 1;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/sew_sector_decode.sv
module sew_sector_decode
    import sew_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [N_SECT-1:0] sel
);
    logic [BLK_W-1:0] blk;
    assign blk = addr[ADDR_W-1:BLK_LSB];

    for (genvar g = 0; g < N_SECT; g++) begin : g_sect
        localparam logic [BLK_W-1:0] FIRST = BLK_W'(sect_first_blk(g));
        localparam logic [BLK_W-1:0] SIZE  = BLK_W'(sect_num_blk(g));
        logic [BLK_W-1:0] offs;
        assign offs   = blk - FIRST;
        assign sel[g] = (offs < SIZE);
    end
endmodule

// File: rtl/sew_window_timer.sv
module sew_window_timer #(
    parameter int CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    input  logic run,
    output logic zero
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = RELOAD;
        end else if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sect_erase_window.sv
module sect_erase_window
    import sew_pkg::*;
#(
    parameter int CLK_MHZ    = 50,
    parameter int WIN_US     = 50,
    parameter int WIN_CYCLES = CLK_MHZ * WIN_US
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_vld,
    input  logic [ADDR_W-1:0] add_addr,
    input  logic              abort,
    input  logic              suspend,
    input  logic              erase_done,
    output logic [N_SECT-1:0] sector_mask,
    output logic              win_active,
    output logic              win_expired,
    output logic              erase_start
);
    sew_regs_t         r_d, r_q;
    logic [N_SECT-1:0] add_sel;
    logic              tmr_load, tmr_clear, tmr_zero, tmr_run;

    sew_sector_decode u_dec (
        .addr (add_addr),
        .sel  (add_sel)
    );

    sew_window_timer #(.CYCLES(WIN_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .clear (tmr_clear),
        .run   (tmr_run),
        .zero  (tmr_zero)
    );

    assign tmr_run = (r_q.st == ST_COLLECT);

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        tmr_load  = 1'b0;
        tmr_clear = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (add_vld) begin
                    r_d.st   = ST_COLLECT;
                    r_d.mask = add_sel;
                    tmr_load = 1'b1;
                end
            end
            ST_COLLECT: begin
                // suspend is tolerated here: it neither clears nor restarts
                if (abort) begin
                    r_d.st    = ST_IDLE;
                    r_d.mask  = '0;
                    tmr_clear = 1'b1;
                end else if (add_vld) begin
                    r_d.mask = r_q.mask | add_sel;
                    tmr_load = 1'b1;
                end else if (tmr_zero) begin
                    r_d.st    = ST_ERASE;
                    r_d.start = 1'b1;
                end
            end
            ST_ERASE: begin
                if (erase_done) begin
                    r_d.st   = ST_IDLE;
                    r_d.mask = '0;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.mask = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.mask  <= '0;
            r_q.start <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sector_mask = r_q.mask;
    assign win_active  = (r_q.st == ST_COLLECT);
    assign win_expired = (r_q.st == ST_ERASE);
    assign erase_start = r_q.start;

    logic unused_ok;
    assign unused_ok = suspend;
endmodule

// File: rtl/sew_checker.sv
module sew_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        add_vld,
    input logic        abort,
    input logic        erase_done,
    input logic [6:0]  sector_mask,
    input logic        win_active,
    input logic        win_expired,
    input logic        erase_start
);
    AST_IDLE_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_active && !win_expired) |-> (sector_mask == 7'd0)); // R1

    AST_ADD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (add_vld && !abort && !win_expired) |=> (win_active && sector_mask != 7'd0)); // R3

    AST_STATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_active && win_expired)); // R6

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start); // R6

    AST_START_ENTERS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_expired) |-> (erase_start && $past(win_active))); // R6

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_active && abort) |=> (sector_mask == 7'd0 && !win_active && !win_expired)); // R7

    AST_ERASE_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_expired && !erase_done) |=> (win_expired && $stable(sector_mask))); // R9

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (win_expired && erase_done) |=> (!win_expired && sector_mask == 7'd0)); // R10
endmodule

bind sect_erase_window sew_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .add_vld     (add_vld),
    .abort       (abort),
    .erase_done  (erase_done),
    .sector_mask (sector_mask),
    .win_active  (win_active),
    .win_expired (win_expired),
    .erase_start (erase_start)
);

// File: tb/sect_erase_window_test.sv
module sect_erase_window_test;
    localparam int W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        add_vld = 1'b0;
    logic [16:0] add_addr = '0;
    logic        abort = 1'b0;
    logic        suspend = 1'b0;
    logic        erase_done = 1'b0;
    logic [6:0]  sector_mask;
    logic        win_active, win_expired, erase_start;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sect_erase_window #(.WIN_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .add_vld(add_vld), .add_addr(add_addr),
        .abort(abort), .suspend(suspend), .erase_done(erase_done),
        .sector_mask(sector_mask), .win_active(win_active),
        .win_expired(win_expired), .erase_start(erase_start)
    );

    // sector index from byte address (R2 map)
    function automatic int sect_of(input int a);
        if (a < 'h08000) return 0;
        if (a < 'h10000) return 1;
        if (a < 'h18000) return 2;
        if (a < 'h1C000) return 3;
        if (a < 'h1D000) return 4;
        if (a < 'h1E000) return 5;
        return 6;
    endfunction

    // behavioural model: 0 idle, 1 collecting, 2 erasing
    int m_mode = 0;
    int m_mask = 0;
    int m_age = 0;
    int m_start = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_mask = 0; m_age = 0; m_start = 0;
        end else begin
            m_start = 0;
            if (m_mode == 0) begin
                if (add_vld) begin
                    m_mode = 1; m_mask = 1 << sect_of(int'(add_addr)); m_age = 0;
                end
            end else if (m_mode == 1) begin
                if (abort) begin
                    m_mode = 0; m_mask = 0;
                end else if (add_vld) begin
                    m_mask = m_mask | (1 << sect_of(int'(add_addr))); m_age = 0;
                end else if (m_age == W - 1) begin
                    m_mode = 2; m_start = 1;
                end else begin
                    m_age++;
                end
            end else begin
                if (erase_done) begin
                    m_mode = 0; m_mask = 0;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R4 mask", int'(sector_mask), m_mask);
            check("R5 active", int'(win_active), int'(m_mode == 1));
            check("R6 expired", int'(win_expired), int'(m_mode == 2));
            check("R6 start", int'(erase_start), m_start);
        end
    end

    task automatic idle_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_add(input int a);
        @(negedge clk); add_vld = 1'b1; add_addr = 17'(a);
        @(negedge clk); add_vld = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    task automatic do_done();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
    endtask

    // cycles from now until erase_start is seen (0 if never within limit)
    task automatic wait_start(output int n);
        n = 0;
        for (int i = 1; i <= W + 4; i++) begin
            @(negedge clk);
            if (erase_start && n == 0) n = i;
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int addrs [14] = '{'h00000, 'h07FFF, 'h08000, 'h0FFFF, 'h10000, 'h17FFF,
                           'h18000, 'h1BFFF, 'h1C000, 'h1CFFF, 'h1D000, 'h1DFFF,
                           'h1E000, 'h1FFFF};
        int exps  [14] = '{0, 0, 1, 1, 2, 2, 3, 3, 4, 4, 5, 5, 6, 6};
        int n;
        int msk;

        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 mask", int'(sector_mask), 0);
        check("R1 flags", int'({win_active, win_expired, erase_start}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 abort while idle does nothing
        do_abort();
        check("R7 idle abort", int'({win_active, win_expired}), 0);

        // R2 / R3 decode at every sector edge
        for (int i = 0; i < 14; i++) begin
            do_add(addrs[i]);
            check("R3 active", int'(win_active), 1);
            check("R2 decode", int'(sector_mask), 1 << exps[i]);
            do_abort();
            check("R7 cleared", int'(sector_mask), 0);
        end

        // R7 no erase after abort
        do_add('h05000);
        do_abort();
        wait_start(n);
        check("R7 no start", n, 0);

        // R4 / R5 / R8 chained adds at just-in-window gaps with suspend
        do_add('h1E800);
        idle_cyc(W - 2);
        do_add('h00100);
        idle_cyc(3);
        @(negedge clk); suspend = 1'b1;
        @(negedge clk); suspend = 1'b0;
        check("R8 mask", int'(sector_mask), 'h41);
        idle_cyc(W - 7);
        do_add('h1D400);
        do_add('h1D800);
        check("R4 mask or", int'(sector_mask), 'h61);
        check("R5 still open", int'(win_active), 1);
        wait_start(n);
        check("R5 expiry cycle", n, W);
        check("R6 expired", int'(win_expired), 1);

        // R8 suspend mid-window does not move expiry
        do_erase_cycle_R9(msk);
        do_done();
        check("R10 released", int'({win_expired, 7'(sector_mask)}), 0);

        do_add('h09000);
        idle_cyc(4);
        @(negedge clk); suspend = 1'b1;
        @(negedge clk); suspend = 1'b0;
        check("R8 active", int'(win_active), 1);
        // R10 erase_done outside erase ignored
        do_done();
        check("R10 ignored", int'(sector_mask), 'h02);
        wait_start(n);
        check("R8 expiry unmoved", n, W - 8);

        do_done();

        // R11 abort beats add in same cycle
        do_add('h12000);
        @(negedge clk); abort = 1'b1; add_vld = 1'b1; add_addr = 17'h1F000;
        @(negedge clk); abort = 1'b0; add_vld = 1'b0;
        check("R11 abort wins", int'({win_active, 7'(sector_mask)}), 0);

        idle_cyc(3);
        finish_run();
    end

    // R9 adds and aborts ignored while erasing
    task automatic do_erase_cycle_R9(output int m);
        m = int'(sector_mask);
        do_add('h14000);
        check("R9 add ignored", int'(sector_mask), m);
        do_abort();
        check("R9 abort ignored", int'({win_expired, 7'(sector_mask)}), (1 << 7) | m);
    endtask
endmodule